// File: doc/BRIEF.md
# Scanline Countdown Interrupt Generator

This block counts the lines a video renderer draws and raises an interrupt request to the CPU after a programmed number of them. The CPU writes the 8-bit countdown value directly, switches counting on and off, and can park a byte in a side register that does not take part in counting. The renderer supplies one pulse per scanline together with the scanline number and a flag that says whether drawing is enabled.

A pulse is counted only on a visible line, with drawing on and counting enabled. A counted pulse that finds the counter at zero raises the interrupt, wraps the counter to 0xFF and switches counting off. The interrupt is a level: it stays high until the CPU writes one of the block's registers. Software sets the counter to N and enables counting, and the interrupt then arrives on the (N+1)-th counted line.

The CPU write interface is a plain one-cycle strobe with address and data and has no back-pressure, because every write completes in the cycle it is presented. The scanline input is also a single-cycle pulse with no handshake. The only outputs are the interrupt level and the stored side byte.

Top module: `cdn_scanline_irq`

## Requirements
- R1: After reset the interrupt is low, the side byte reads 0x00, the counter holds 0 and counting is disabled, so enabling counting and then applying one counted pulse raises the interrupt.
- R2: A write to address 0xC000 loads the counter with the data byte and drops a pending interrupt on the next cycle.
- R3: A write to address 0xC001 places the data byte on `latch_q` on the next cycle and drops a pending interrupt. The stored byte does not change how many pulses remain before the interrupt.
- R4: A write to address 0xE000 or 0xE002 disables counting and drops a pending interrupt.
- R5: A write to address 0xE001 or 0xE003 enables counting and drops a pending interrupt.
- R6: A pulse is counted only when `line_num` is between 0 and 239 inclusive, `render_on` is 1 and counting is enabled. Any other pulse leaves the counter and the interrupt unchanged.
- R7: A counted pulse with a nonzero counter decrements the counter by one and does not raise the interrupt.
- R8: A counted pulse with the counter at 0 raises the interrupt one cycle later, sets the counter to 0xFF and disables counting. Once counting is enabled again, the interrupt is next raised after 256 counted pulses.
- R9: Once raised, the interrupt stays high until a write to 0xC000, 0xC001 or 0xE000 to 0xE003. Writes to any other address have no effect.
- R10: When a register write and a scanline pulse arrive in the same cycle, the write takes effect and the pulse is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_tick | input | 1 | One-cycle pulse per scanline |
| line_num | input | 9 | Number of the scanline that the pulse belongs to |
| render_on | input | 1 | High while the renderer is drawing |
| irq | output | 1 | Active-high level interrupt request |
| latch_q | output | 8 | Byte stored by the last write to 0xC001 |

## Verification
The assertions assume that `wr_en` and `line_tick` are single-cycle strobes sampled on the rising clock edge, and that `line_num` is valid whenever `line_tick` is high. They also assume that all inputs are stable across the edge. The bench changes every input one time unit after a rising edge and holds it for a full cycle, and it raises each strobe for exactly one cycle. Simultaneous write and pulse cycles are created on purpose, only to check R10.

// File: rtl/cdn_pkg.sv
package cdn_pkg;
  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_LOAD,
    CMD_LATCH,
    CMD_OFF,
    CMD_ON
  } cmd_e;
endpackage

// File: rtl/cdn_decode.sv
module cdn_decode
  import cdn_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] LOAD_ADDR  = 16'hC000,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 16'hC001,
  parameter logic [ADDR_W-1:0] CTRL_BASE  = 16'hE000,
  parameter int CTRL_SPAN = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output cmd_e              cmd
);
  localparam logic [ADDR_W:0] CTRL_END = {1'b0, CTRL_BASE} + (ADDR_W+1)'(CTRL_SPAN);

  logic in_ctrl;
  assign in_ctrl = ({1'b0, wr_addr} >= {1'b0, CTRL_BASE}) && ({1'b0, wr_addr} < CTRL_END);

  always_comb begin
    cmd = CMD_NONE;
    if (wr_en) begin
      if (wr_addr == LOAD_ADDR)       cmd = CMD_LOAD;
      else if (wr_addr == LATCH_ADDR) cmd = CMD_LATCH;
      else if (in_ctrl)               cmd = wr_addr[0] ? CMD_ON : CMD_OFF;
    end
  end
endmodule

// File: rtl/cdn_qualify.sv
module cdn_qualify #(
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic              line_tick,
  input  logic [LINE_W-1:0] line_num,
  input  logic              render_on,
  output logic              tick_ok
);
  localparam logic [LINE_W-1:0] LAST_L = LINE_W'(LAST_LINE);
  assign tick_ok = line_tick && render_on && (line_num <= LAST_L);
endmodule

// File: rtl/cdn_count.sv
module cdn_count
  import cdn_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             tick_ok,
  output logic [CNT_W-1:0] cnt_q,
  output logic             en_q,
  output logic             pend_q,
  output logic [CNT_W-1:0] latch_q
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= ZERO;
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
      latch_q <= ZERO;
    end else if (cmd != CMD_NONE) begin
      pend_q <= 1'b0;
      unique case (cmd)
        CMD_LOAD:  cnt_q   <= wr_data;
        CMD_LATCH: latch_q <= wr_data;
        CMD_OFF:   en_q    <= 1'b0;
        CMD_ON:    en_q    <= 1'b1;
        default:   ;
      endcase
    end else if (tick_ok && en_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == ZERO) begin
        en_q   <= 1'b0;
        pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cdn_scanline_irq.sv
module cdn_scanline_irq
  import cdn_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 8,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              line_tick,
  input  logic [LINE_W-1:0] line_num,
  input  logic              render_on,
  output logic              irq,
  output logic [CNT_W-1:0]  latch_q
);
  cmd_e             cmd;
  logic             tick_ok;
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic             pend_q;

  cdn_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .cmd(cmd)
  );

  cdn_qualify #(.LINE_W(LINE_W), .LAST_LINE(LAST_LINE)) u_qual (
    .line_tick(line_tick), .line_num(line_num), .render_on(render_on), .tick_ok(tick_ok)
  );

  cdn_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .wr_data(wr_data), .tick_ok(tick_ok),
    .cnt_q(cnt_q), .en_q(en_q), .pend_q(pend_q), .latch_q(latch_q)
  );

  assign irq = pend_q;
endmodule

// File: rtl/cdn_chk.sv
module cdn_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_addr,
  input logic [7:0]  wr_data,
  input logic        line_tick,
  input logic [8:0]  line_num,
  input logic        render_on,
  input logic        irq,
  input logic [7:0]  latch_q,
  input logic [7:0]  cnt,
  input logic        en
);
  logic hit, vis;
  assign hit = wr_en && (wr_addr == 16'hC000 || wr_addr == 16'hC001 ||
                         wr_addr[15:2] == 14'h3800);
  assign vis = line_tick && render_on && (line_num < 9'd240);

  AST_HIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !irq); // R9
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !hit) |=> irq); // R9
  AST_LATCH_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 16'hC001) |=> latch_q == $past(wr_data)); // R3
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 16'hC000) |=> cnt == $past(wr_data)); // R2
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (vis && en && !hit && cnt != 8'd0) |=> (cnt == $past(cnt) - 8'd1) && !irq); // R7
  AST_WRAP_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (vis && en && !hit && cnt == 8'd0) |=> (cnt == 8'hFF) && !en && irq); // R8
  AST_IGNORED_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !(vis && en)) |=> $stable(cnt)); // R6
  AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(vis && !hit)); // R10
endmodule

bind cdn_scanline_irq cdn_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .line_tick(line_tick), .line_num(line_num), .render_on(render_on),
  .irq(irq), .latch_q(latch_q), .cnt(cnt_q), .en(en_q)
);

// File: tb/tb_cdn_scanline_irq.sv
module tb_cdn_scanline_irq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       line_tick = 1'b0;
  logic [8:0] line_num = '0;
  logic       render_on = 1'b0;
  logic       irq;
  logic [7:0] latch_q;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdn_scanline_irq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .line_tick(line_tick), .line_num(line_num), .render_on(render_on),
    .irq(irq), .latch_q(latch_q)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: inputs driven 1 unit after an edge, sampled 1 unit after the next
  task automatic cyc(input bit w, input logic [15:0] a, input logic [7:0] d,
                     input bit t, input int ln, input bit r);
    wr_en = w; wr_addr = a; wr_data = d;
    line_tick = t; line_num = 9'(ln); render_on = r;
    @(posedge clk); #1;
    wr_en = 1'b0; line_tick = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0, 0, 1'b1);
  endtask

  task automatic vtick(input int ln);
    cyc(1'b0, 16'h0, 8'h0, 1'b1, ln, 1'b1);
  endtask

  task automatic run_to_irq(output int n);
    n = 0;
    while (!irq && n < 400) begin
      vtick(n % 240);
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R1 irq", irq, 0);
    check("R1 latch", latch_q, 0);
    wr(16'hE001, 8'h0);
    vtick(5);
    check("R1 zero counter fires on first tick", irq, 1);

    // R2/R7/R8: sweep every load value, irq on tick N+1
    for (int v = 0; v < 256; v++) begin
      wr(16'hC000, 8'(v));
      check("R2 load clears irq", irq, 0);
      wr(16'hE001, 8'h0);
      run_to_irq(n);
      check("R7 ticks to irq", n, v + 1);
    end

    // R8: after firing the counter has wrapped to 0xFF
    wr(16'hE003, 8'h0);
    check("R5 enable clears irq", irq, 0);
    run_to_irq(n);
    check("R8 wrap count", n, 256);
    // R8: enable was cleared by firing -> further ticks ignored
    wr(16'hC001, 8'h5A);
    check("R3 latch clears irq", irq, 0);
    check("R3 latch value", latch_q, 8'h5A);
    vtick(1);
    check("R8 enable dropped on fire", irq, 0);

    // R6: ignored pulses
    wr(16'hC000, 8'd3);
    wr(16'hE001, 8'h0);
    vtick(240);
    vtick(300);
    cyc(1'b0, 16'h0, 8'h0, 1'b1, 10, 1'b0);
    wr(16'hE002, 8'h0);
    vtick(3);
    wr(16'hE001, 8'h0);
    check("R6 no irq from ignored pulses", irq, 0);
    run_to_irq(n);
    check("R6 count after ignored pulses", n, 4);

    // R4: disable while pending and stops counting
    wr(16'hE000, 8'h0);
    check("R4 disable clears irq", irq, 0);
    vtick(0); vtick(239);
    check("R4 disabled no count", irq, 0);

    // R3: latch write mid-count does not change counting
    wr(16'hC000, 8'd4);
    wr(16'hE001, 8'h0);
    vtick(0); vtick(1);
    wr(16'hC001, 8'h00);
    check("R3 latch zero", latch_q, 0);
    run_to_irq(n);
    check("R3 remaining ticks unchanged", n, 3);

    // R9: other addresses do not clear; irq holds
    wr(16'h8000, 8'hFF);
    wr(16'hA000, 8'h01);
    wr(16'hE004, 8'h00);
    wr(16'hC002, 8'h00);
    repeat (5) cyc(1'b0, 16'h0, 8'h0, 1'b0, 0, 1'b0);
    check("R9 irq held", irq, 1);
    check("R9 latch untouched", latch_q, 0);
    wr(16'hC000, 8'd2);
    check("R9 load clears", irq, 0);

    // R10: write and tick together -> write wins
    wr(16'hE001, 8'h0);
    cyc(1'b1, 16'hC000, 8'd1, 1'b1, 7, 1'b1);
    run_to_irq(n);
    check("R10 load beats tick", n, 2);
    wr(16'hC000, 8'd0);
    cyc(1'b1, 16'hE001, 8'h0, 1'b1, 7, 1'b1);
    check("R10 enable write beats tick", irq, 0);
    run_to_irq(n);
    check("R10 count after enable+tick", n, 1);
    wr(16'hC000, 8'd0);
    wr(16'hE001, 8'h0);
    cyc(1'b1, 16'hE000, 8'h0, 1'b1, 7, 1'b1);
    check("R10 disable beats zero tick", irq, 0);
    vtick(8);
    check("R10 stays disabled", irq, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule